// File: doc/BRIEF.md
# Three-Master Shared Bus Arbiter with Release Handoff

This block lets three bus masters share one external address bus and one data bus. The masters are a test controller, an auxiliary memory controller and a static memory controller. Each master raises a request line and receives a grant line. The block routes the address, data-out and data-drive-enable of the master that owns the bus onto the shared outputs. The incoming external data is sent to all three masters unchanged.

Priority is fixed: the test controller ranks highest and the static memory controller ranks lowest. When a master that outranks the current owner requests the bus, the owner loses its grant on the next clock edge. The owner keeps the bus until it finishes its transfer and lowers its request. Only then does the block pass ownership to the highest-ranked master that is waiting.

When the bus is idle it stays with the static memory controller. That master can therefore begin an access at once, with no arbitration delay. A master that has given up the bus may request again one cycle later. It then waits to be granted again.

Top module: `shared_bus_arbiter`

## Requirements
- R1: While reset is low and on the first cycle after it, only the static controller's grant is high. Reset is synchronous and active low. Grant vectors in this document are written {test, aux, static}, so this state is 001.
- R2: With no request present, or with only the static controller requesting, the static controller's grant stays high. The static controller is therefore served with zero wait.
- R3: If the owner's request is high and a higher-priority master requests, the owner's grant is low after the next rising edge.
- R4: No grant is given to another master, and the shared outputs keep following the owner, for as long as the owner's request stays high. This holds even while the owner's grant is revoked.
- R5: On the edge where the owner's request is sampled low, the grant goes to the highest-priority master that is requesting.
- R6: Suppose the static controller is mid-transfer and the aux controller requests. If the static controller lowers its request in the cycle after its grant drops, the aux grant is high exactly two edges after the aux request was first sampled.
- R7: A master that released the bus and requests again gets no grant while a higher-priority owner holds the bus.
- R8: At most one grant output is high in any cycle.
- R9: While the owner is granted or still requesting, the shared address, data-out and drive-enable equal that owner's lines.
- R10: In a handover cycle (owner not granted and not requesting), the drive-enable is low and the data-out is zero. The address holds the value it had on the previous edge.
- R11: The external data input appears unchanged on all three masters' data inputs in the same cycle.
- R12: When the owner releases and no master is requesting, the grant returns to the static controller.
- R13: If the higher-priority request is withdrawn before the revoked owner releases, the owner's grant is high again after the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tst_req | input | 1 | Test controller bus request |
| tst_gnt | output | 1 | Test controller bus grant |
| tst_addr | input | ADDR_W | Test controller address |
| tst_dout | input | DATA_W | Test controller write data |
| tst_den | input | 1 | Test controller data drive enable |
| tst_din | output | DATA_W | External read data to test controller |
| aux_req | input | 1 | Aux controller bus request |
| aux_gnt | output | 1 | Aux controller bus grant |
| aux_addr | input | ADDR_W | Aux controller address |
| aux_dout | input | DATA_W | Aux controller write data |
| aux_den | input | 1 | Aux controller data drive enable |
| aux_din | output | DATA_W | External read data to aux controller |
| smc_req | input | 1 | Static controller bus request |
| smc_gnt | output | 1 | Static controller bus grant |
| smc_addr | input | ADDR_W | Static controller address |
| smc_dout | input | DATA_W | Static controller write data |
| smc_den | input | 1 | Static controller data drive enable |
| smc_din | output | DATA_W | External read data to static controller |
| bus_addr | output | ADDR_W | Shared address bus |
| bus_dout | output | DATA_W | Shared write data bus |
| bus_den | output | 1 | Shared data drive enable (active high) |
| bus_din | input | DATA_W | External read data |

## Verification
Grants are registered. A request change driven at a falling edge shows up on the grant lines one rising edge later, so the bench checks grants at the next falling edge. The routed bus outputs and the read-data fanout are combinational in the current state. The bench checks them a fraction of a cycle after the inputs change, before any edge. The two-edge aux handoff is counted edge by edge: the revoke is checked one falling edge after the aux request, and the new grant one falling edge after the static controller drops its request. The held address in a handover cycle is compared with the address the bus carried before the edge.

// File: rtl/sba_pkg.sv
// Package: shared constants and helpers for the shared bus arbiter.
// Assumes a fixed set of three masters; a lower index means higher priority.
package sba_pkg;
    localparam int NUM_M  = 3;
    localparam int IDX_W  = $clog2(NUM_M);

    localparam logic [IDX_W-1:0] M_TST     = 2'd0;
    localparam logic [IDX_W-1:0] M_AUX     = 2'd1;
    localparam logic [IDX_W-1:0] M_SMC     = 2'd2;
    localparam logic [IDX_W-1:0] M_DEFAULT = M_SMC;

    // Builds the one-hot grant vector that selects a single master.
    function automatic logic [NUM_M-1:0] onehot(input logic [IDX_W-1:0] idx);
        logic [NUM_M-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_M; i++) begin
            if (idx == IDX_W'(i)) v[i] = 1'b1;
        end
        return v;
    endfunction
endpackage

// File: rtl/sba_prio_pick.sv
// Module: fixed-priority picker.
// Returns the lowest-indexed (highest-priority) active request and a found flag.
// Assumes N >= 1 and IW wide enough to hold N-1.
module sba_prio_pick #(
    parameter int N  = 3,
    parameter int IW = 2
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // Scan from lowest to highest priority so the highest-priority hit wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/sba_grant_ctrl.sv
// Module: grant and ownership state for the shared bus.
// Revokes the owner's grant when a higher-priority master requests. It moves
// ownership only on an edge where the owner's request is low. An idle bus
// defaults to the static controller.
// Assumes requests are synchronous to clk.
module sba_grant_ctrl
    import sba_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NUM_M-1:0] req,
    output logic [NUM_M-1:0] gnt,
    output logic [IDX_W-1:0] owner,
    output logic             owner_req,
    output logic             parked
);
    logic [IDX_W-1:0] owner_q, owner_d;
    logic [NUM_M-1:0] gnt_q, gnt_d;
    logic             pick_found;
    logic [IDX_W-1:0] pick_idx;
    logic             higher_req;

    sba_prio_pick #(.N(NUM_M), .IW(IDX_W)) pick_i (
        .req   (req),
        .found (pick_found),
        .idx   (pick_idx)
    );

    // Detect any request that outranks the current owner.
    always_comb begin
        higher_req = 1'b0;
        for (int i = 0; i < NUM_M; i++) begin
            if ((IDX_W'(i) < owner_q) && req[i]) higher_req = 1'b1;
        end
    end

    // Next owner and grant: hold or revoke while the owner requests, else hand over.
    always_comb begin
        owner_req = req[owner_q];
        if (owner_req) begin
            owner_d = owner_q;
            gnt_d   = higher_req ? '0 : onehot(owner_q);
        end else begin
            owner_d = pick_found ? pick_idx : M_DEFAULT;
            gnt_d   = onehot(owner_d);
        end
    end

    // Register ownership and grants; reset parks the bus on the static controller.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner_q <= M_DEFAULT;
            gnt_q   <= onehot(M_DEFAULT);
        end else begin
            owner_q <= owner_d;
            gnt_q   <= gnt_d;
        end
    end

    // Publish the state and flag the handover cycle (owner neither granted nor requesting).
    always_comb begin
        gnt    = gnt_q;
        owner  = owner_q;
        parked = !owner_req && !gnt_q[owner_q];
    end
endmodule

// File: rtl/sba_bus_steer.sv
// Module: steers the owning master's address, data and enable onto the shared bus.
// In a handover cycle it drives a safe value: enable low, data zero, address held.
// Assumes the owner index is always below N.
module sba_bus_steer #(
    parameter int N      = 3,
    parameter int IW     = 2,
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N-1:0][ADDR_W-1:0]     m_addr,
    input  logic [N-1:0][DATA_W-1:0]     m_dout,
    input  logic [N-1:0]                 m_den,
    input  logic [IW-1:0]                owner,
    input  logic                         parked,
    output logic [ADDR_W-1:0]            bus_addr,
    output logic [DATA_W-1:0]            bus_dout,
    output logic                         bus_den
);
    logic [ADDR_W-1:0] held_addr_q;

    // Select the owner's lines, or the safe default while parked.
    always_comb begin
        if (parked) begin
            bus_addr = held_addr_q;
            bus_dout = '0;
            bus_den  = 1'b0;
        end else begin
            bus_addr = m_addr[owner];
            bus_dout = m_dout[owner];
            bus_den  = m_den[owner];
        end
    end

    // Remember the last address on the bus for use in handover cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) held_addr_q <= '0;
        else        held_addr_q <= bus_addr;
    end
endmodule

// File: rtl/shared_bus_arbiter.sv
// Module: top of the three-master shared bus arbiter.
// It packs the per-master ports, runs the grant control and steers the bus.
// It fans the external read data out to every master.
// Assumes all masters share clk and obey grant revoke by releasing their request.
module shared_bus_arbiter
    import sba_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tst_req,
    output logic              tst_gnt,
    input  logic [ADDR_W-1:0] tst_addr,
    input  logic [DATA_W-1:0] tst_dout,
    input  logic              tst_den,
    output logic [DATA_W-1:0] tst_din,
    input  logic              aux_req,
    output logic              aux_gnt,
    input  logic [ADDR_W-1:0] aux_addr,
    input  logic [DATA_W-1:0] aux_dout,
    input  logic              aux_den,
    output logic [DATA_W-1:0] aux_din,
    input  logic              smc_req,
    output logic              smc_gnt,
    input  logic [ADDR_W-1:0] smc_addr,
    input  logic [DATA_W-1:0] smc_dout,
    input  logic              smc_den,
    output logic [DATA_W-1:0] smc_din,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_den,
    input  logic [DATA_W-1:0] bus_din
);
    logic [NUM_M-1:0]             req_v;
    logic [NUM_M-1:0]             gnt_v;
    logic [NUM_M-1:0][ADDR_W-1:0] addr_v;
    logic [NUM_M-1:0][DATA_W-1:0] dout_v;
    logic [NUM_M-1:0]             den_v;
    logic [IDX_W-1:0]             owner_w;
    logic                         owner_req_w;
    logic                         parked_w;

    // Pack the per-master ports into arrays indexed by priority.
    always_comb begin
        req_v[M_TST]  = tst_req;
        req_v[M_AUX]  = aux_req;
        req_v[M_SMC]  = smc_req;
        addr_v[M_TST] = tst_addr;
        addr_v[M_AUX] = aux_addr;
        addr_v[M_SMC] = smc_addr;
        dout_v[M_TST] = tst_dout;
        dout_v[M_AUX] = aux_dout;
        dout_v[M_SMC] = smc_dout;
        den_v[M_TST]  = tst_den;
        den_v[M_AUX]  = aux_den;
        den_v[M_SMC]  = smc_den;
    end

    sba_grant_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req_v),
        .gnt       (gnt_v),
        .owner     (owner_w),
        .owner_req (owner_req_w),
        .parked    (parked_w)
    );

    sba_bus_steer #(
        .N      (NUM_M),
        .IW     (IDX_W),
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) steer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .m_addr   (addr_v),
        .m_dout   (dout_v),
        .m_den    (den_v),
        .owner    (owner_w),
        .parked   (parked_w),
        .bus_addr (bus_addr),
        .bus_dout (bus_dout),
        .bus_den  (bus_den)
    );

    // Unpack grants and fan out the external read data unswitched.
    always_comb begin
        tst_gnt = gnt_v[M_TST];
        aux_gnt = gnt_v[M_AUX];
        smc_gnt = gnt_v[M_SMC];
        tst_din = bus_din;
        aux_din = bus_din;
        smc_din = bus_din;
    end
endmodule

// File: rtl/sba_checker.sv
// Module: assertion checker bound to the arbiter top.
// Assumes index 0 is the test controller, 1 the aux controller and 2 the static controller.
module sba_checker
    import sba_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [NUM_M-1:0] req_v,
    input logic [NUM_M-1:0] gnt_v,
    input logic [IDX_W-1:0] owner,
    input logic             owner_req,
    input logic             bus_den
);
    // R8
    at_most_one_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt_v));

    // R1
    reset_default_gnt_chk: assert property (@(posedge clk)
        !rst_n |=> (gnt_v == 3'b100));

    // R3
    revoke_smc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_v[2] && gnt_v[2] && (req_v[1] || req_v[0])) |=> !gnt_v[2]);

    // R3
    revoke_aux_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_v[1] && gnt_v[1] && req_v[0]) |=> !gnt_v[1]);

    // R4
    owner_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        owner_req |=> (owner == $past(owner)));

    // R5
    tst_wins_handover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!owner_req && req_v[0]) |=> gnt_v[0]);

    // R10
    park_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!owner_req && !gnt_v[owner]) |-> !bus_den);

    // R12
    idle_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!owner_req && (req_v == '0)) |=> gnt_v[2]);
endmodule

bind shared_bus_arbiter sba_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_v     (req_v),
    .gnt_v     (gnt_v),
    .owner     (owner_w),
    .owner_req (owner_req_w),
    .bus_den   (bus_den)
);

// File: tb/shared_bus_arbiter_tb_top.sv
module shared_bus_arbiter_tb_top;
    localparam int ADDR_W = 24;
    localparam int DATA_W = 16;

    logic clk = 1'b0;
    logic rst_n;
    logic tst_req, aux_req, smc_req;
    logic tst_gnt, aux_gnt, smc_gnt;
    logic [ADDR_W-1:0] tst_addr, aux_addr, smc_addr, bus_addr;
    logic [DATA_W-1:0] tst_dout, aux_dout, smc_dout, bus_dout;
    logic tst_den, aux_den, smc_den, bus_den;
    logic [DATA_W-1:0] tst_din, aux_din, smc_din, bus_din;

    int n_run = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    shared_bus_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .tst_req(tst_req), .tst_gnt(tst_gnt), .tst_addr(tst_addr),
        .tst_dout(tst_dout), .tst_den(tst_den), .tst_din(tst_din),
        .aux_req(aux_req), .aux_gnt(aux_gnt), .aux_addr(aux_addr),
        .aux_dout(aux_dout), .aux_den(aux_den), .aux_din(aux_din),
        .smc_req(smc_req), .smc_gnt(smc_gnt), .smc_addr(smc_addr),
        .smc_dout(smc_dout), .smc_den(smc_den), .smc_din(smc_din),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_den(bus_den),
        .bus_din(bus_din)
    );

    // Each entry is {req{tst,aux,smc}, expected gnt{tst,aux,smc}} one edge later.
    localparam int NV = 21;
    localparam logic [5:0] VEC_TBL [NV] = '{
        6'b000_001,  // R2 idle default
        6'b001_001,  // R2 static served at once
        6'b011_000,  // R3 aux preempts static
        6'b011_000,  // R4 static still requesting
        6'b010_010,  // R5 handover to aux
        6'b011_010,  // R7 static re-requests, waits
        6'b111_000,  // R3 test preempts aux
        6'b101_100,  // R5 highest waiting wins
        6'b101_100,  // R7 static still waiting
        6'b001_001,  // R5 back to static
        6'b000_001,  // R12 idle
        6'b010_010,  // R5 aux from idle default
        6'b000_001,  // R12 return to static
        6'b100_100,  // R5 test from idle
        6'b110_100,  // R4 lower request does not revoke
        6'b010_010,  // R5 test releases to aux
        6'b000_001,  // R12
        6'b001_001,  // R2
        6'b011_000,  // R13 revoke
        6'b001_001,  // R13 regrant after withdrawal
        6'b000_001   // R12
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] gnts();
        return {29'd0, tst_gnt, aux_gnt, smc_gnt};
    endfunction

    task automatic set_req(input logic [2:0] r);
        {tst_req, aux_req, smc_req} = r;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        set_req(3'b000);
        tst_addr = 24'h000111; tst_dout = 16'h1111; tst_den = 1'b1;
        aux_addr = 24'h000222; aux_dout = 16'h2222; aux_den = 1'b1;
        smc_addr = 24'h000333; smc_dout = 16'h3333; smc_den = 1'b1;
        bus_din  = 16'h0000;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1 reset grant", gnts(), 32'b001);
        rst_n = 1'b1;
        #2;
        chk("R1 first cycle grant", gnts(), 32'b001);
        chk("R9 idle static addr", 32'(bus_addr), 32'h333);

        // Vector walk: apply at a falling edge, check at the next falling edge.
        for (int i = 0; i < NV; i++) begin
            set_req(VEC_TBL[i][5:3]);
            @(negedge clk);
            chk($sformatf("R2-table vec %0d grant", i), gnts(), 32'(VEC_TBL[i][2:0]));
            chk($sformatf("R8 vec %0d onehot", i), 32'($countones(gnts()) <= 1), 32'd1);
        end

        // R6 exact two-edge aux handoff, with R4 and R10 on the way.
        set_req(3'b011);
        @(negedge clk);
        chk("R6 static revoked after one edge", gnts(), 32'b000);
        chk("R4 revoked owner keeps addr", 32'(bus_addr), 32'h333);
        chk("R4 revoked owner keeps den", 32'(bus_den), 32'd1);
        set_req(3'b010);
        smc_addr = 24'h0003AB;
        #2;
        chk("R10 park den low", 32'(bus_den), 32'd0);
        chk("R10 park addr held", 32'(bus_addr), 32'h333);
        chk("R10 park dout zero", 32'(bus_dout), 32'h0);
        @(negedge clk);
        chk("R6 aux granted after second edge", gnts(), 32'b010);
        chk("R9 aux addr", 32'(bus_addr), 32'h222);
        chk("R9 aux dout", 32'(bus_dout), 32'h2222);

        // Test controller takes over from aux.
        set_req(3'b110);
        @(negedge clk);
        chk("R3 aux revoked", gnts(), 32'b000);
        chk("R4 aux still drives", 32'(bus_dout), 32'h2222);
        set_req(3'b100);
        @(negedge clk);
        chk("R5 test granted", gnts(), 32'b100);
        chk("R9 test addr", 32'(bus_addr), 32'h111);
        chk("R9 test dout", 32'(bus_dout), 32'h1111);
        tst_den = 1'b0;
        #2;
        chk("R9 test den follows", 32'(bus_den), 32'd0);

        // R11 read data fanout.
        bus_din = 16'hA5C3;
        #2;
        chk("R11 tst din", 32'(tst_din), 32'hA5C3);
        chk("R11 aux din", 32'(aux_din), 32'hA5C3);
        chk("R11 smc din", 32'(smc_din), 32'hA5C3);

        // R1 reset in the middle of a test ownership.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 mid-run reset grant", gnts(), 32'b001);
        rst_n = 1'b1;
        set_req(3'b000);
        @(negedge clk);
        chk("R12 after reset idle", gnts(), 32'b001);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule